// File: doc/BRIEF.md
# Receiver Output Readiness and Gating

This block sits behind a parallel video receiver and decides when the recovered pixel data and its output strobe may be driven. It runs on the recovered pixel clock. A startup wait counter counts pixel clock cycles while a clock-present flag is high and the device is powered up. A two-bit readiness mode chooses the release condition: a base wait, a doubled wait, the base wait together with PLL lock, or release as soon as the clock is present.

Once the outputs are released, each of the two output banks (even and odd) carries five 7-bit channels. A bank-enable pin can force a whole bank low. A per-channel disable bit can force a single channel low. Every gate is applied in one registered output stage, so all data bits change on the same pixel clock edge. The output strobe is the pixel clock, or its inverse, chosen by a polarity input. It is held low while the outputs are not released.

Top module: `rx_ready_gate`

## Requirements
- R1: In readiness mode 2'b00, with the clock present and power up from reset release, `ready_out` rises on clock edge WAIT_BASE+1.
- R2: In readiness mode 2'b01, under the same conditions, `ready_out` rises on clock edge 2*WAIT_BASE+1.
- R3: In readiness mode 2'b10, `ready_out` rises only at the edge after both of these hold: at least WAIT_BASE cycles have been counted, and `pll_lock` is high. It falls at the edge after `pll_lock` goes low.
- R4: In readiness mode 2'b11, `ready_out` follows `clk_present` (with power up), delayed by one edge, whatever the count or lock state.
- R5: A low `clk_present` or a low `pwrdn_n` at a clock edge clears the wait count and drops `ready_out` at that edge. The full wait for the current mode must then be counted again.
- R6: While `pwrdn_n` is low, both data buses, `ready_out` and `strobe_out` are low from the next edge on.
- R7: A low `even_en` forces all of `even_out` to zero at the next edge. A low `odd_en` does the same for `odd_out`.
- R8: Bit i of `even_chan_off` (or `odd_chan_off`) set to 1 forces channel i of that bank to zero. Channel i occupies bits [7i+6:7i] of the bus. A 0 bit lets the channel through.
- R9: `strobe_out` equals `clk` when `strobe_rise` is 1 and the inverse of `clk` when it is 0, whenever `ready_out` is high. It is 0 while `ready_out` is low.
- R10: The wait count saturates at 2*WAIT_BASE. While the clock stays present and power stays up, `ready_out` never drops, however long the run.
- R11: Data outputs are registered. While ready, each enabled channel shows the input value sampled at the previous clock edge. While not ready, the data outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_present | input | 1 | High while an input clock is detected |
| pll_lock | input | 1 | High while the PLL strobes are locked |
| pwrdn_n | input | 1 | Active-low powerdown; low disables all outputs |
| even_en | input | 1 | Even bank enable, low forces the bank to zero |
| odd_en | input | 1 | Odd bank enable, low forces the bank to zero |
| ready_mode | input | 2 | Readiness mode select (00 base, 01 double, 10 base plus lock, 11 clock only) |
| even_chan_off | input | N_CH | Per-channel disable bits for the even bank |
| odd_chan_off | input | N_CH | Per-channel disable bits for the odd bank |
| strobe_rise | input | 1 | Strobe polarity: 1 rising-edge strobe, 0 falling-edge strobe |
| even_in | input | N_CH*CH_W | Recovered even-bank parallel data |
| odd_in | input | N_CH*CH_W | Recovered odd-bank parallel data |
| even_out | output | N_CH*CH_W | Gated, registered even-bank data |
| odd_out | output | N_CH*CH_W | Gated, registered odd-bank data |
| ready_out | output | 1 | Registered readiness, aligned with the data |
| strobe_out | output | 1 | Polarity-selected output strobe |

## Verification
The bench builds the block with WAIT_BASE set to 8, which leaves the channel count and width at their defaults. With that value, both wait lengths, saturation at 16 counts and many restarts after clock loss or powerdown all fit in a few hundred cycles. The small wait also leaves room to sweep every combination of the two 5-bit channel-disable masks, along with all four bank-enable pairs and both strobe polarities. A cycle-level model in the bench, built from the requirements, predicts the readiness and the gated data on every cycle.

// File: rtl/rxg_pkg.sv
package rxg_pkg;
    typedef enum logic [1:0] {
        RDY_BASE      = 2'b00,
        RDY_DOUBLE    = 2'b01,
        RDY_BASE_LOCK = 2'b10,
        RDY_CLK_ONLY  = 2'b11
    } rdy_mode_e;
endpackage

// File: rtl/rxg_wait_timer.sv
module rxg_wait_timer
    import rxg_pkg::*;
#(
    parameter int WAIT_BASE = 1024
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clk_present,
    input  logic       pll_lock,
    input  logic       pwrdn_n,
    input  logic [1:0] mode,
    output logic       ready_ok
);
    localparam int LIMIT = 2 * WAIT_BASE;
    localparam int CW    = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] BASE_C  = CW'(WAIT_BASE);
    localparam logic [CW-1:0] LIMIT_C = CW'(LIMIT);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t s_d, s_q;
    logic run;

    always_comb begin
        s_d = s_q;
        run = clk_present && pwrdn_n;
        if (!run) begin
            s_d.cnt = '0;
        end else if (s_q.cnt != LIMIT_C) begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
        unique case (rdy_mode_e'(mode))
            RDY_BASE:      ready_ok = run && (s_q.cnt >= BASE_C);
            RDY_DOUBLE:    ready_ok = run && (s_q.cnt == LIMIT_C);
            RDY_BASE_LOCK: ready_ok = run && (s_q.cnt >= BASE_C) && pll_lock;
            RDY_CLK_ONLY:  ready_ok = run;
            default:       ready_ok = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R5: losing the clock or powering down restarts the wait
    p_wait_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_present || !pwrdn_n) |=> (s_q.cnt == '0));

    // R10: the count holds at its terminal value
    p_wait_sat_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.cnt == LIMIT_C && clk_present && pwrdn_n) |=> (s_q.cnt == LIMIT_C));
endmodule

// File: rtl/rxg_bank_gate.sv
module rxg_bank_gate #(
    parameter int N_CH = 5,
    parameter int CH_W = 7
) (
    input  logic [N_CH*CH_W-1:0] data_in,
    input  logic                 bank_en,
    input  logic [N_CH-1:0]      chan_off,
    output logic [N_CH*CH_W-1:0] data_out
);
    for (genvar i = 0; i < N_CH; i++) begin : g_chan
        assign data_out[i*CH_W +: CH_W] =
            (bank_en && !chan_off[i]) ? data_in[i*CH_W +: CH_W] : '0;
    end
endmodule

// File: rtl/rxg_out_stage.sv
module rxg_out_stage #(
    parameter int BW = 35
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ready_ok,
    input  logic [BW-1:0] even_g,
    input  logic [BW-1:0] odd_g,
    output logic          ready_q_o,
    output logic [BW-1:0] even_q_o,
    output logic [BW-1:0] odd_q_o
);
    typedef struct packed {
        logic          ready;
        logic [BW-1:0] even;
        logic [BW-1:0] odd;
    } ost_t;

    ost_t o_d, o_q;

    always_comb begin
        o_d.ready = ready_ok;
        o_d.even  = ready_ok ? even_g : '0;
        o_d.odd   = ready_ok ? odd_g  : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign ready_q_o = o_q.ready;
    assign even_q_o  = o_q.even;
    assign odd_q_o   = o_q.odd;

    // R11: data never leaves the stage while not ready
    p_quiet_when_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !o_q.ready |-> (o_q.even == '0 && o_q.odd == '0));
endmodule

// File: rtl/rx_ready_gate.sv
module rx_ready_gate
    import rxg_pkg::*;
#(
    parameter int WAIT_BASE = 1024,
    parameter int N_CH      = 5,
    parameter int CH_W      = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clk_present,
    input  logic                 pll_lock,
    input  logic                 pwrdn_n,
    input  logic                 even_en,
    input  logic                 odd_en,
    input  logic [1:0]           ready_mode,
    input  logic [N_CH-1:0]      even_chan_off,
    input  logic [N_CH-1:0]      odd_chan_off,
    input  logic                 strobe_rise,
    input  logic [N_CH*CH_W-1:0] even_in,
    input  logic [N_CH*CH_W-1:0] odd_in,
    output logic [N_CH*CH_W-1:0] even_out,
    output logic [N_CH*CH_W-1:0] odd_out,
    output logic                 ready_out,
    output logic                 strobe_out
);
    localparam int BW = N_CH * CH_W;

    logic          ready_ok;
    logic [BW-1:0] even_g, odd_g;

    rxg_wait_timer #(.WAIT_BASE(WAIT_BASE)) u_timer (
        .clk(clk), .rst_n(rst_n), .clk_present(clk_present),
        .pll_lock(pll_lock), .pwrdn_n(pwrdn_n), .mode(ready_mode),
        .ready_ok(ready_ok)
    );

    rxg_bank_gate #(.N_CH(N_CH), .CH_W(CH_W)) u_even_gate (
        .data_in(even_in), .bank_en(even_en), .chan_off(even_chan_off),
        .data_out(even_g)
    );

    rxg_bank_gate #(.N_CH(N_CH), .CH_W(CH_W)) u_odd_gate (
        .data_in(odd_in), .bank_en(odd_en), .chan_off(odd_chan_off),
        .data_out(odd_g)
    );

    rxg_out_stage #(.BW(BW)) u_out (
        .clk(clk), .rst_n(rst_n), .ready_ok(ready_ok),
        .even_g(even_g), .odd_g(odd_g),
        .ready_q_o(ready_out), .even_q_o(even_out), .odd_q_o(odd_out)
    );

    assign strobe_out = ready_out && (strobe_rise ? clk : ~clk);

    // R6: powerdown silences every output at the next edge
    p_pd_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !pwrdn_n |=> (even_out == '0 && odd_out == '0 && !ready_out));

    // R7: bank enables
    p_even_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !even_en |=> (even_out == '0));
    p_odd_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !odd_en |=> (odd_out == '0));

    // R4: readiness is never granted without a clock on the previous edge
    p_rdy_needs_clk_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_out) |-> $past(clk_present));
endmodule

// File: tb/rx_ready_gate_test.sv
module rx_ready_gate_test;
    localparam int WB = 8;
    localparam int NC = 5;
    localparam int CW = 7;
    localparam int BW = NC * CW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clk_present = 1'b0, pll_lock = 1'b0, pwrdn_n = 1'b0;
    logic          even_en = 1'b1, odd_en = 1'b1, strobe_rise = 1'b1;
    logic [1:0]    ready_mode = 2'b00;
    logic [NC-1:0] even_chan_off = '0, odd_chan_off = '0;
    logic [BW-1:0] even_in = '0, odd_in = '0;
    logic [BW-1:0] even_out, odd_out;
    logic          ready_out, strobe_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    rx_ready_gate #(.WAIT_BASE(WB), .N_CH(NC), .CH_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .clk_present(clk_present), .pll_lock(pll_lock),
        .pwrdn_n(pwrdn_n), .even_en(even_en), .odd_en(odd_en),
        .ready_mode(ready_mode), .even_chan_off(even_chan_off),
        .odd_chan_off(odd_chan_off), .strobe_rise(strobe_rise),
        .even_in(even_in), .odd_in(odd_in), .even_out(even_out),
        .odd_out(odd_out), .ready_out(ready_out), .strobe_out(strobe_out)
    );

    // Reference model from the requirements
    int            m_cnt;
    logic          m_rdy;
    logic [BW-1:0] m_even, m_odd;
    logic          m_ok;

    function automatic logic [BW-1:0] gate(logic [BW-1:0] d, logic en, logic [NC-1:0] off);
        logic [BW-1:0] r = '0;
        for (int i = 0; i < NC; i++)
            if (en && !off[i]) r[i*CW +: CW] = d[i*CW +: CW];
        return r;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt <= 0; m_rdy <= 1'b0; m_even <= '0; m_odd <= '0;
        end else begin
            case (ready_mode)
                2'b00:   m_ok = (m_cnt >= WB);
                2'b01:   m_ok = (m_cnt >= 2 * WB);
                2'b10:   m_ok = (m_cnt >= WB) && pll_lock;
                default: m_ok = 1'b1;
            endcase
            m_ok = m_ok && clk_present && pwrdn_n;
            m_rdy  <= m_ok;
            m_even <= m_ok ? gate(even_in, even_en, even_chan_off) : '0;
            m_odd  <= m_ok ? gate(odd_in, odd_en, odd_chan_off) : '0;
            if (!clk_present || !pwrdn_n) m_cnt <= 0;
            else if (m_cnt < 2 * WB)      m_cnt <= m_cnt + 1;
        end
    end

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic string rdy_tag();
        case (ready_mode)
            2'b00:   return "R1";
            2'b01:   return "R2";
            2'b10:   return "R3";
            default: return "R4";
        endcase
    endfunction

    function automatic string dat_tag(logic en, logic [NC-1:0] off);
        if (!pwrdn_n) return "R6";
        if (!en)      return "R7";
        if (off != 0) return "R8";
        return "R11";
    endfunction

    // One cycle: compare at the falling edge, then drive fresh data
    task automatic cyc();
        @(negedge clk);
        chk(rdy_tag(), 64'(ready_out), 64'(m_rdy));
        chk(dat_tag(even_en, even_chan_off), 64'(even_out), 64'(m_even));
        chk(dat_tag(odd_en, odd_chan_off), 64'(odd_out), 64'(m_odd));
        chk("R9", 64'(strobe_out), 64'(m_rdy && !strobe_rise));
        even_in = {$urandom, $urandom};
        odd_in  = {$urandom, $urandom};
    endtask

    task automatic run(int n);
        for (int k = 0; k < n; k++) cyc();
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(20 * 150000);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", 64'(ready_out), 64'd0);
        chk("R6", 64'({even_out, odd_out} != 0), 64'd0);
        rst_n = 1'b1; clk_present = 1'b1; pwrdn_n = 1'b1;

        // R1: base wait, explicit edge check
        run(WB);
        chk("R1", 64'(ready_out), 64'd0);
        run(1);
        chk("R1", 64'(ready_out), 64'd1);
        run(10);

        // R9: strobe follows the clock in the high phase
        @(posedge clk); #5;
        chk("R9", 64'(strobe_out), 64'd1);
        strobe_rise = 1'b0; #1;
        chk("R9", 64'(strobe_out), 64'd0);
        run(6);
        strobe_rise = 1'b1;

        // R5: clock loss restarts the wait
        clk_present = 1'b0; run(1);
        chk("R5", 64'(ready_out), 64'd0);
        clk_present = 1'b1; run(3);
        chk("R5", 64'(ready_out), 64'd0);
        run(WB + 4);

        // R2: doubled wait after a restart
        ready_mode = 2'b01; pwrdn_n = 1'b0; run(3);
        pwrdn_n = 1'b1; run(2 * WB + 4);

        // R3: wait plus lock
        ready_mode = 2'b10; clk_present = 1'b0; run(1);
        clk_present = 1'b1; run(WB + 6);
        chk("R3", 64'(ready_out), 64'd0);
        pll_lock = 1'b1; run(5);
        pll_lock = 1'b0; run(3);
        pll_lock = 1'b1; run(3);

        // R4: clock-only release
        ready_mode = 2'b11; clk_present = 1'b0; run(2);
        clk_present = 1'b1; run(2);
        chk("R4", 64'(ready_out), 64'd1);

        // R10: long run in base mode never drops readiness
        ready_mode = 2'b00; run(20 * WB);
        chk("R10", 64'(ready_out), 64'd1);

        // R6: powerdown mid-stream
        pwrdn_n = 1'b0; run(4);
        chk("R6", 64'(strobe_out), 64'd0);
        pwrdn_n = 1'b1; run(WB + 3);

        // R7, R8: bank enables and exhaustive channel masks
        ready_mode = 2'b11;
        for (int b = 0; b < 4; b++) begin
            even_en = b[0]; odd_en = b[1];
            run(4);
        end
        even_en = 1'b1; odd_en = 1'b1;
        for (int e = 0; e < 32; e++) begin
            for (int o = 0; o < 32; o++) begin
                even_chan_off = NC'(e); odd_chan_off = NC'(o);
                strobe_rise = o[0];
                cyc();
            end
        end
        even_chan_off = '0; odd_chan_off = '0; strobe_rise = 1'b1;
        run(4);
        finish_up();
    end
endmodule